// File: doc/BRIEF.md
# Saturating Fractional Multiplier

This block multiplies two signed fractions in Q(N-1) format and returns their product in the same format. The product is truncated toward minus infinity and is never allowed to wrap. There is only one pair of operands whose true product cannot be represented: minus one times minus one. For that pair the block returns the largest positive fraction and raises a flag.

The overflow case is recognised from the operands alone, so the detector works in parallel with the partial-product array. Its result is merged into the carry-save vectors before the final adder. The block also brings out those two merged vectors. An accumulating stage downstream can then add them without waiting for a carry to propagate.

The width is set by parameter (N of at least 4, default 16). A parameter also chooses between a registered output, which gives one cycle of latency (the default), and a purely combinational path.

Top module: `sat_frac_mul`

## Requirements
- R1: For every operand pair other than minus one times minus one, `prod` equals floor(a*b / 2^(N-1)) taken as an N-bit two's complement value, where a and b are the operands read as signed integers.
- R2: `sat` is 1 exactly when both operands equal the code with only the top bit set (0x8000 at N=16); otherwise it is 0.
- R3: When `sat` is 1, `prod` equals the code with every bit set except the top bit (0x7FFF at N=16).
- R4: When both operands are nonzero and `sat` is 0, bit N-1 of `prod` equals the XOR of the operands' top bits.
- R5: When either operand is zero, `prod` is zero and `sat` is 0.
- R6: Take bits 2N-2 down to N-1 of (`cs_sum` + `cs_carry`) modulo 2^(2N). These bits always equal `prod`, and this includes the saturated case.
- R7: With the registered output selected, a change on the operands reaches every output after exactly one rising clock edge, and the outputs hold their values between edges.
- R8: A rising edge with `rst_n` low clears `prod`, `sat`, `cs_sum` and `cs_carry` to zero.
- R9: At full scale with N=16, 0x8000 times 0x7FFF gives 0x8001 with `sat` low, 0x7FFF times 0x7FFF gives 0x7FFE, and 0x8000 times 0x8001 gives 0x7FFF with `sat` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | N | Multiplicand, signed Q(N-1) |
| op_b | input | N | Multiplier, signed Q(N-1) |
| prod | output | N | Truncated, saturated product, signed Q(N-1) |
| sat | output | 1 | High when the product was clamped |
| cs_sum | output | 2N | Sum vector of the merged carry-save product |
| cs_carry | output | 2N | Carry vector of the merged carry-save product |

## Verification
The bench targets several corner cases.

- **Minus one squared.** A design without the clamp returns 0x8000, which is minus one, with the flag low.
- **Minus one times 0x8001.** This pair produces the clamp value through ordinary arithmetic. A detector that looks only at the top bits would raise the flag here by mistake.
- **Tiny negative products.** These must floor to all ones. A design that truncates toward zero would return zero.
- **Full-scale positive square (0x7FFF squared).** An error in the sign-correction constants of the array shows up here as a wrong top bit.
- **Carry-save vectors during saturation.** If saturation were applied only after the final adder, an accumulator fed from the vectors would receive minus one instead of the clamp value.

Every 8-bit operand pair is checked against an integer model, and random 16-bit pairs are checked as well.

// File: rtl/sfm_pkg.sv
// Package: shared constants and width helpers for the saturating
// fractional multiplier. Assumes nothing beyond integer arithmetic.
package sfm_pkg;

    // Narrowest operand width the array generator supports
    localparam int unsigned SFM_MIN_WIDTH = 4;

    // Width of the unresolved product vectors for an n-bit operand
    function automatic int unsigned sfm_cs_width(input int unsigned n);
        return 2 * n;
    endfunction

endpackage

// File: rtl/sfm_sat_detect.sv
// Saturation detector: flags the single unrepresentable product, the
// most negative code times itself. Uses only the operands, so it settles
// long before the partial-product array. Assumes N >= 2.
module sfm_sat_detect #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic         sat
);

    // Both signs set and every magnitude bit clear
    always_comb begin
        sat = op_a[N-1] & op_b[N-1] & ~(|op_a[N-2:0]) & ~(|op_b[N-2:0]);
    end

endmodule

// File: rtl/sfm_csa.sv
// Carry-save adder: compresses three W-bit vectors into a sum and a
// left-shifted carry vector, with all arithmetic modulo 2^W.
module sfm_csa #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);

    logic [W-1:0] maj;

    // Bitwise full-adder sum and majority
    always_comb begin
        s   = x ^ y ^ z;
        maj = (x & y) | (x & z) | (y & z);
        c   = {maj[W-2:0], 1'b0};
    end

endmodule

// File: rtl/sfm_pp_array.sv
// Signed partial-product array. It forms N sign-corrected rows plus one
// constant row, then reduces them with a linear chain of carry-save
// adders down to two 2N-bit vectors. The saturation bit then forces the
// vectors so that their sum carries the clamp value. Assumes N >= 4.
module sfm_pp_array #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    input  logic           sat,
    output logic [2*N-1:0] vec_s,
    output logic [2*N-1:0] vec_c
);

    localparam int unsigned W = sfm_pkg::sfm_cs_width(N);

    // Correction row that turns the inverted sign cross terms into the
    // negative weights they stand for: +2^N and +2^(2N-1) modulo 2^W
    localparam logic [W-1:0] CORR_ROW = (W'(1) << N) | (W'(1) << (W-1));

    // Forced sum vector for saturation: bits 2N-3..0 set, so that the
    // product field (bits 2N-2..N-1) reads 0 followed by all ones
    localparam logic [W-1:0] CLAMP_ROW = {2'b00, {(W-2){1'b1}}};

    // One row per multiplier bit
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        logic [W-1:0] r;

        // AND terms; the terms that cross a sign bit are inverted
        always_comb begin
            r = '0;
            for (int j = 0; j < N; j++) begin
                if ((gi == N - 1) != (j == N - 1)) begin
                    r[gi + j] = ~(op_a[gi] & op_b[j]);
                end else begin
                    r[gi + j] = op_a[gi] & op_b[j];
                end
            end
        end
    end

    // Linear reduction: each stage folds in one more row
    for (genvar gk = 0; gk < N - 1; gk++) begin : g_csa
        logic [W-1:0] in0;
        logic [W-1:0] in1;
        logic [W-1:0] s;
        logic [W-1:0] c;

        if (gk == 0) begin : g_first
            assign in0 = CORR_ROW;
            assign in1 = g_row[0].r;
        end else begin : g_next
            assign in0 = g_csa[gk-1].s;
            assign in1 = g_csa[gk-1].c;
        end

        sfm_csa #(.W(W)) u_csa (
            .x (in0),
            .y (in1),
            .z (g_row[gk+1].r),
            .s (s),
            .c (c)
        );
    end

    // Merge the early saturation bit into the carry-save pair
    always_comb begin
        vec_s = sat ? CLAMP_ROW : g_csa[N-2].s;
        vec_c = sat ? '0        : g_csa[N-2].c;
    end

endmodule

// File: rtl/sfm_cpa.sv
// Final carry-propagate adder: resolves the carry-save pair modulo 2^W.
module sfm_cpa #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);

    // Plain two-operand addition, carry out dropped
    always_comb begin
        sum = x + y;
    end

endmodule

// File: rtl/sat_frac_mul.sv
// Saturating Q(N-1) fractional multiplier, top level.
// Combines the operand-only saturation detector, the sign-corrected
// carry-save array and the final adder. The fraction is bits 2N-2..N-1
// of the resolved product, which is a left shift by one followed by
// truncation. REG_OUT=1 adds one register stage with a synchronous
// active-low reset; REG_OUT=0 leaves clk and rst_n unused.
module sat_frac_mul #(
    parameter int unsigned N       = 16,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [N-1:0]   prod,
    output logic           sat,
    output logic [2*N-1:0] cs_sum,
    output logic [2*N-1:0] cs_carry
);

    localparam int unsigned W = sfm_pkg::sfm_cs_width(N);

    logic           sat_c;
    logic [W-1:0]   vs_c;
    logic [W-1:0]   vc_c;
    logic [W-1:0]   full_c;
    logic [N-1:0]   prod_c;

    sfm_sat_detect #(.N(N)) u_detect (
        .op_a (op_a),
        .op_b (op_b),
        .sat  (sat_c)
    );

    sfm_pp_array #(.N(N)) u_array (
        .op_a  (op_a),
        .op_b  (op_b),
        .sat   (sat_c),
        .vec_s (vs_c),
        .vec_c (vc_c)
    );

    sfm_cpa #(.W(W)) u_cpa (
        .x   (vs_c),
        .y   (vc_c),
        .sum (full_c)
    );

    // Pick the fractional field out of the resolved product
    always_comb begin
        prod_c = full_c[W-2:N-1];
    end

    if (REG_OUT) begin : g_reg
        // Output register stage, cleared by the synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod     <= '0;
                sat      <= 1'b0;
                cs_sum   <= '0;
                cs_carry <= '0;
            end else begin
                prod     <= prod_c;
                sat      <= sat_c;
                cs_sum   <= vs_c;
                cs_carry <= vc_c;
            end
        end
    end else begin : g_comb
        // Combinational pass-through
        always_comb begin
            prod     = prod_c;
            sat      = sat_c;
            cs_sum   = vs_c;
            cs_carry = vc_c;
        end
    end

endmodule

// File: rtl/sat_frac_mul_chk.sv
// Property checker for sat_frac_mul, attached by bind. It keeps its own
// copy of the operands one cycle back so that it can relate the outputs
// to the inputs that produced them.
module sat_frac_mul_chk #(
    parameter int unsigned N       = 16,
    parameter bit          REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [N-1:0]   prod,
    input logic           sat,
    input logic [2*N-1:0] cs_sum,
    input logic [2*N-1:0] cs_carry
);

    localparam logic [N-1:0] MIN_CODE = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAX_CODE = {1'b0, {(N-1){1'b1}}};

    logic           primed;
    logic [N-1:0]   a_q;
    logic [N-1:0]   b_q;
    logic [N-1:0]   a_use;
    logic [N-1:0]   b_use;
    logic [2*N-1:0] cs_tot;

    // Operand history and a flag that is set once a full cycle has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
        end else begin
            primed <= 1'b1;
            a_q    <= op_a;
            b_q    <= op_b;
        end
    end

    // Operands that the current outputs belong to
    always_comb begin
        a_use  = REG_OUT ? a_q : op_a;
        b_use  = REG_OUT ? b_q : op_b;
        cs_tot = cs_sum + cs_carry;
    end

    // R3
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> (prod == MAX_CODE));

    // R2
    sat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (sat == ((a_use == MIN_CODE) && (b_use == MIN_CODE))));

    // R6
    cs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (cs_tot[2*N-2:N-1] == prod));

    // R4
    sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !sat && a_use != '0 && b_use != '0)
        |-> (prod[N-1] == (a_use[N-1] ^ b_use[N-1])));

    // R5
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && (a_use == '0 || b_use == '0)) |-> (prod == '0 && !sat));

    if (REG_OUT) begin : g_rst
        // R8
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (prod == '0 && !sat && cs_sum == '0 && cs_carry == '0));
    end

endmodule

bind sat_frac_mul sat_frac_mul_chk #(.N(N), .REG_OUT(REG_OUT)) u_sat_frac_mul_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_b     (op_b),
    .prod     (prod),
    .sat      (sat),
    .cs_sum   (cs_sum),
    .cs_carry (cs_carry)
);

// File: tb/test_sat_frac_mul.sv
// Bench for sat_frac_mul: a 16-bit instance driven from a vector table and
// random operands, and an 8-bit instance walked over every operand pair.
module test_sat_frac_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;
    logic [15:0] p16;
    logic        s16;
    logic [31:0] cs16;
    logic [31:0] cc16;
    logic [7:0]  a8 = '0;
    logic [7:0]  b8 = '0;
    logic [7:0]  p8;
    logic        s8;
    logic [15:0] cs8;
    logic [15:0] cc8;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sat_frac_mul #(.N(16), .REG_OUT(1'b1)) i_sat_frac_mul (
        .clk (clk), .rst_n (rst_n), .op_a (a16), .op_b (b16),
        .prod (p16), .sat (s16), .cs_sum (cs16), .cs_carry (cc16)
    );

    sat_frac_mul #(.N(8), .REG_OUT(1'b1)) i_sat_frac_mul_w8 (
        .clk (clk), .rst_n (rst_n), .op_a (a8), .op_b (b8),
        .prod (p8), .sat (s8), .cs_sum (cs8), .cs_carry (cc8)
    );

    // Table: {a, b, expected product, expected flag}
    localparam int NV = 12;
    localparam logic [48:0] VEC [NV] = '{
        {16'h8000, 16'h8000, 16'h7FFF, 1'b1},
        {16'h8000, 16'h7FFF, 16'h8001, 1'b0},
        {16'h7FFF, 16'h7FFF, 16'h7FFE, 1'b0},
        {16'h8000, 16'h0001, 16'hFFFF, 1'b0},
        {16'h0001, 16'h0001, 16'h0000, 1'b0},
        {16'hFFFF, 16'h0001, 16'hFFFF, 1'b0},
        {16'h4000, 16'h4000, 16'h2000, 1'b0},
        {16'hC000, 16'h4000, 16'hE000, 1'b0},
        {16'h8000, 16'hFFFF, 16'h0001, 1'b0},
        {16'h0000, 16'h8000, 16'h0000, 1'b0},
        {16'h6000, 16'hA000, 16'hB800, 1'b0},
        {16'h8000, 16'h8001, 16'h7FFF, 1'b0}
    };

    // Integer model of the requirements: floor division, with the clamp
    function automatic longint ref_frac(input longint a, input longint b, input int n);
        longint lo;
        lo = -(longint'(1) << (n - 1));
        if (a == lo && b == lo) return (longint'(1) << (n - 1)) - 1;
        return (a * b) >>> (n - 1);
    endfunction

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        longint e;
        logic [31:0] t16;
        logic [15:0] t8;

        // R8: reset clears the outputs even with nonzero operands applied
        a16 = 16'h8000; b16 = 16'h8000; a8 = 8'h80; b8 = 8'h80;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(p16 == 0 && s16 == 0 && cs16 == 0 && cc16 == 0, "R8 reset state 16-bit", longint'(p16), 0);
        check(p8 == 0 && s8 == 0, "R8 reset state 8-bit", longint'(p8), 0);
        rst_n = 1'b1;

        // R1 R3 R9: walk the vector table
        for (int k = 0; k < NV; k++) begin
            a16 = VEC[k][48:33]; b16 = VEC[k][32:17];
            @(negedge clk);
            check(p16 == VEC[k][16:1], $sformatf("R1 R3 R9 table entry %0d prod", k),
                  longint'(p16), longint'(VEC[k][16:1]));
            check(s16 == VEC[k][0], $sformatf("R2 table entry %0d flag", k),
                  longint'(s16), longint'(VEC[k][0]));
            t16 = cs16 + cc16;
            check(t16[30:15] == VEC[k][16:1], $sformatf("R6 table entry %0d carry-save field", k),
                  longint'(t16[30:15]), longint'(VEC[k][16:1]));
        end

        // R7: output holds before the edge and updates right after it
        a16 = 16'h4000; b16 = 16'h4000;
        @(negedge clk);
        a16 = 16'hC000;
        #1;
        check(p16 == 16'h2000, "R7 output held before edge", longint'(p16), 16'h2000);
        @(negedge clk);
        check(p16 == 16'hE000, "R7 output after one edge", longint'(p16), 16'hE000);

        // R5: zero against varied operands
        for (int k = 0; k < 8; k++) begin
            a16 = 16'h0000; b16 = 16'(k * 16'h1357 + 16'h8000);
            @(negedge clk);
            check(p16 == 0 && s16 == 0, "R5 zero operand", longint'(p16), 0);
        end

        // R1 R2 R4 R6: every 8-bit pair, random 16-bit pairs alongside
        for (int k = 0; k < 65536; k++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            a8 = k[15:8]; b8 = k[7:0];
            ra = 16'($urandom); rb = 16'($urandom);
            if (k % 1024 == 0) ra = 16'h8000;
            a16 = ra; b16 = rb;
            @(negedge clk);
            e = ref_frac(longint'($signed(a8)), longint'($signed(b8)), 8);
            check(p8 == e[7:0], "R1 R3 8-bit exhaustive prod", longint'(p8), e & 8'hFF);
            check(s8 == (a8 == 8'h80 && b8 == 8'h80), "R2 8-bit flag", longint'(s8),
                  longint'(a8 == 8'h80 && b8 == 8'h80));
            t8 = cs8 + cc8;
            check(t8[14:7] == p8, "R6 8-bit carry-save field", longint'(t8[14:7]), longint'(p8));
            e = ref_frac(longint'($signed(ra)), longint'($signed(rb)), 16);
            check(p16 == e[15:0], "R1 16-bit random prod", longint'(p16), e & 16'hFFFF);
            if (ra != 0 && rb != 0 && !s16)
                check(p16[15] == (ra[15] ^ rb[15]), "R4 16-bit sign", longint'(p16[15]),
                      longint'(ra[15] ^ rb[15]));
            t16 = cs16 + cc16;
            check(t16[30:15] == p16, "R6 16-bit carry-save field", longint'(t16[30:15]), longint'(p16));
        end

        // R8: reset asserted mid-run clears live outputs
        a16 = 16'h7FFF; b16 = 16'h7FFF;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(p16 == 0 && s16 == 0 && cs16 == 0 && cc16 == 0, "R8 mid-run reset", longint'(p16), 0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule